// File: doc/BRIEF.md
# Display filter and line-interrupt control

This block is the software-facing control point for the scaler and flicker-filter path of a display engine. A single control word holds the interrupt scan line, an interlace-fetch switch, two filter enables, and the address and target of an indirect RAM window. Software writes the filter enables at any time. They are held in a staging copy and move into the active copies only on a frame or field start pulse from the timing generator, so a frame is never filtered half one way and half the other.

When the incoming scan-line number equals the programmed line, a sticky flag is set. The interrupt output is that flag gated by a mask bit. Software clears the flag by writing a one to it. The same control word also opens a window onto five small RAMs: three line buffers and two flicker-filter coefficient stores. The window uses an 8-bit entry address and a pair of 16-bit data halves. The RAMs themselves are plain arrays here.

Top module: `disp_filt_ctrl`

## Requirements
- R1: After reset, the registers at word addresses 0 (control), 1 (mask) and 2 (status) read as zero, and every output is low, with `alpha_nearest` high.
- R2: If `scan_line` equals control bits 26:16 on a clock edge, the line flag (status bit 0) is set at that edge and stays set while no clear happens.
- R3: `line_irq` is high exactly when the line flag is set and mask bit 0 (word address 1) is clear.
- R4: A write to control bit 12 (graphics filter) or bit 14 (alpha filter) appears on control readback at once. It changes `gfx_filt_act` and `alpha_filt_act` (also on status bits 1 and 2) only at the edge where `frame_start` is high.
- R5: A control write that lands in the same cycle as `frame_start` is not loaded by that pulse. The active copies take the previously staged values, and the new values load at the next pulse.
- R6: `alpha_nearest` is high whenever the active graphics filter enable or the active alpha filter enable is low.
- R7: Control bit 9 enables the RAM window, and bits 7:0 give the entry address. With bit 10 clear, bits 30:29 select line buffer 0, 1 or 2. With bit 10 set, they select flicker RAM 0 or 1. Writing word address 4 holds the high half. Writing word address 3 stores {high, low} into the selected entry. Reading word address 3 or 4 returns that entry's low or high half.
- R8: When bit 9 is clear, or the selected target does not exist (line-buffer code 3, or a flicker code above 1), window writes change no RAM and window reads return zero.
- R9: Control bits 31, 27, 15, 13, 11 and 8, and mask bits 31:1, ignore writes and read as zero.
- R10: Writing 1 to status bit 0 clears the line flag. If a line match happens in the same cycle, the flag stays set.
- R11: Control bit 28 drives `interlace_mode` from the edge after the write, with no frame staging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frame_start | input | 1 | Frame or field start pulse |
| scan_line | input | 11 | Current scan-line number |
| line_irq | output | 1 | Masked line interrupt |
| gfx_filt_act | output | 1 | Active graphics filter enable |
| alpha_filt_act | output | 1 | Active alpha filter enable |
| alpha_nearest | output | 1 | Alpha channel uses nearest-neighbour selection |
| interlace_mode | output | 1 | Fetch every other source line per field |

## Verification
The hardest case to reach is a control write and a frame start arriving on the same edge. The stimulus raises `reg_wr` and `frame_start` together on one falling edge, with a staged value that differs from the new one. It then checks that the active enables take the old staged value and pick up the new one only at a later pulse. The clear-versus-match race on the line flag is reached the same way: the status write and the matching `scan_line` are driven in one cycle. The RAM window is exercised across several targets, to show that the stores are separate and that a disabled or invalid target leaves them untouched.

// File: rtl/disp_filt_pkg.sv
package disp_filt_pkg;

  localparam int DATA_W   = 32;
  localparam int LINE_W   = 11;
  localparam int LINE_LSB = 16;
  localparam int WADDR_W  = 8;
  localparam int SEL_LSB  = 29;
  localparam int B_GFX    = 12;
  localparam int B_ALPHA  = 14;
  localparam int B_WIN_EN = 9;
  localparam int B_BANK   = 10;
  localparam int B_ILACE  = 28;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_MASK = 3'd1,
    RA_STAT = 3'd2,
    RA_WLO  = 3'd3,
    RA_WHI  = 3'd4
  } reg_addr_e;

  function automatic logic [DATA_W-1:0] field_mask(int lsb, int width);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_KEEP =
      field_mask(SEL_LSB, 2) | field_mask(B_ILACE, 1) |
      field_mask(LINE_LSB, LINE_W) | field_mask(B_ALPHA, 1) |
      field_mask(B_GFX, 1) | field_mask(B_BANK, 1) |
      field_mask(B_WIN_EN, 1) | field_mask(0, WADDR_W);

  function automatic logic use_nearest(logic gfx_on, logic alpha_on);
    return !(gfx_on && alpha_on);
  endfunction

  // returns {valid, index}; line buffers take indices 0..nlb-1, flicker RAMs follow
  function automatic logic [3:0] win_slot(logic bank, logic [1:0] sel, int nlb, int nff);
    logic ok;
    int   idx;
    if (bank) begin
      ok  = int'(sel) < nff;
      idx = nlb + int'(sel);
    end else begin
      ok  = int'(sel) < nlb;
      idx = int'(sel);
    end
    return {ok, 3'(idx)};
  endfunction

endpackage

// File: rtl/dfc_ctrl_regs.sv
module dfc_ctrl_regs
  import disp_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_start,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              mask_q,
  output logic              act_gfx,
  output logic              act_alpha
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      mask_q    <= 1'b0;
      act_gfx   <= 1'b0;
      act_alpha <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
      if (wr_mask) mask_q <= wdata[0];
      if (frame_start) begin
        act_gfx   <= ctrl_q[B_GFX];
        act_alpha <= ctrl_q[B_ALPHA];
      end
    end
  end

endmodule

// File: rtl/dfc_line_irq.sv
module dfc_line_irq #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] scan_line,
  input  logic [LW-1:0] line_cfg,
  input  logic          clr,
  output logic          hit,
  output logic          flag
);

  assign hit = (scan_line == line_cfg);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/dfc_ram_window.sv
module dfc_ram_window
  import disp_filt_pkg::*;
#(
  parameter int NUM_LB = 3,
  parameter int NUM_FF = 2,
  parameter int AW     = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bank,
  input  logic [1:0]        sel,
  input  logic [AW-1:0]     addr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi,
  output logic [NUM_LB+NUM_FF-1:0] we
);

  localparam int NUM_RAM = NUM_LB + NUM_FF;
  localparam int DEPTH   = 1 << AW;
  localparam int WORD_W  = 2 * HALF_W;

  logic [3:0]        slot;
  logic              live;
  logic [2:0]        idx;
  logic [HALF_W-1:0] hi_hold;
  logic [WORD_W-1:0] rd_word [NUM_RAM];
  logic [WORD_W-1:0] pick;

  assign slot = win_slot(bank, sel, NUM_LB, NUM_FF);
  assign live = en && slot[3];
  assign idx  = slot[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n)             hi_hold <= '0;
    else if (live && wr_hi) hi_hold <= wdata;
  end

  for (genvar g = 0; g < NUM_RAM; g++) begin : g_ram
    logic [WORD_W-1:0] mem [DEPTH];
    assign we[g] = live && wr_lo && (idx == 3'(g));
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= {hi_hold, wdata};
    end
    assign rd_word[g] = mem[addr];
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_RAM; k++)
      if (live && idx == 3'(k)) pick = rd_word[k];
  end

  assign rd_lo = pick[HALF_W-1:0];
  assign rd_hi = pick[WORD_W-1:HALF_W];

endmodule

// File: rtl/disp_filt_ctrl.sv
module disp_filt_ctrl
  import disp_filt_pkg::*;
#(
  parameter int NUM_LB = 3,
  parameter int NUM_FF = 2,
  parameter int HALF_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        frame_start,
  input  logic [10:0] scan_line,
  output logic        line_irq,
  output logic        gfx_filt_act,
  output logic        alpha_filt_act,
  output logic        alpha_nearest,
  output logic        interlace_mode
);

  localparam int NUM_RAM = NUM_LB + NUM_FF;

  reg_addr_e         ra;
  logic [DATA_W-1:0] ctrl_q;
  logic              mask_bit;
  logic              line_hit;
  logic              line_flag;
  logic              flag_clr;
  logic              stg_gfx;
  logic              stg_alpha;
  logic [HALF_W-1:0] win_lo;
  logic [HALF_W-1:0] win_hi;
  logic [NUM_RAM-1:0] win_we;
  logic [7:0]        we8;

  assign ra       = reg_addr_e'(reg_addr);
  assign flag_clr = reg_wr && ra == RA_STAT && reg_wdata[0];
  assign stg_gfx  = ctrl_q[B_GFX];
  assign stg_alpha = ctrl_q[B_ALPHA];
  assign we8      = 8'(win_we);

  dfc_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(reg_wr && ra == RA_CTRL),
    .wr_mask(reg_wr && ra == RA_MASK),
    .wdata(reg_wdata), .frame_start(frame_start),
    .ctrl_q(ctrl_q), .mask_q(mask_bit),
    .act_gfx(gfx_filt_act), .act_alpha(alpha_filt_act)
  );

  dfc_line_irq #(.LW(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .scan_line(scan_line),
    .line_cfg(ctrl_q[LINE_LSB +: LINE_W]), .clr(flag_clr),
    .hit(line_hit), .flag(line_flag)
  );

  dfc_ram_window #(.NUM_LB(NUM_LB), .NUM_FF(NUM_FF), .AW(WADDR_W), .HALF_W(HALF_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl_q[B_WIN_EN]), .bank(ctrl_q[B_BANK]),
    .sel(ctrl_q[SEL_LSB +: 2]), .addr(ctrl_q[WADDR_W-1:0]),
    .wr_lo(reg_wr && ra == RA_WLO), .wr_hi(reg_wr && ra == RA_WHI),
    .wdata(reg_wdata[HALF_W-1:0]),
    .rd_lo(win_lo), .rd_hi(win_hi), .we(win_we)
  );

  assign line_irq       = line_flag && !mask_bit;
  assign alpha_nearest  = use_nearest(gfx_filt_act, alpha_filt_act);
  assign interlace_mode = ctrl_q[B_ILACE];

  always_comb begin
    case (ra)
      RA_CTRL: reg_rdata = ctrl_q;
      RA_MASK: reg_rdata = {31'b0, mask_bit};
      RA_STAT: reg_rdata = {29'b0, alpha_filt_act, gfx_filt_act, line_flag};
      RA_WLO:  reg_rdata = 32'(win_lo);
      RA_WHI:  reg_rdata = 32'(win_hi);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dfc_checker.sv
module dfc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       stg_gfx,
  input logic       stg_alpha,
  input logic       act_gfx,
  input logic       act_alpha,
  input logic       alpha_nearest,
  input logic       line_hit,
  input logic       line_flag,
  input logic       flag_clr,
  input logic       mask_bit,
  input logic       line_irq,
  input logic [7:0] we8
);

  assert_hold_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_gfx) && $stable(act_alpha));

  assert_load_staged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_gfx == $past(stg_gfx)) && (act_alpha == $past(stg_alpha)));

  assert_hit_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> line_flag);

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_flag && !flag_clr) |=> line_flag);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !line_hit) |=> !line_flag);

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_bit |-> !line_irq);

  assert_nearest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_gfx || !act_alpha) |-> alpha_nearest);

  assert_one_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we8));

endmodule

bind disp_filt_ctrl dfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .stg_gfx(stg_gfx), .stg_alpha(stg_alpha),
  .act_gfx(gfx_filt_act), .act_alpha(alpha_filt_act),
  .alpha_nearest(alpha_nearest), .line_hit(line_hit),
  .line_flag(line_flag), .flag_clr(flag_clr),
  .mask_bit(mask_bit), .line_irq(line_irq), .we8(we8)
);

// File: tb/test_disp_filt_ctrl.sv
`timescale 1ns/1ps
module test_disp_filt_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0;
  logic [10:0] scan_line = 11'd2000;
  logic        line_irq, gfx_filt_act, alpha_filt_act, alpha_nearest, interlace_mode;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  disp_filt_ctrl i_disp_filt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .scan_line(scan_line), .line_irq(line_irq), .gfx_filt_act(gfx_filt_act),
    .alpha_filt_act(alpha_filt_act), .alpha_nearest(alpha_nearest),
    .interlace_mode(interlace_mode)
  );

  // {word address, write data, expected readback}
  localparam logic [66:0] VECS [7] = '{
    {3'd0, 32'hFFFF_FFFF, 32'h77FF_56FF},
    {3'd0, 32'h0000_0000, 32'h0000_0000},
    {3'd0, 32'h8800_A900, 32'h0000_0000},
    {3'd0, 32'h1234_5678, 32'h1234_5678},
    {3'd1, 32'hFFFF_FFFF, 32'h0000_0001},
    {3'd1, 32'hFFFF_FFFE, 32'h0000_0000},
    {3'd0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata, exp, req);
  endtask

  task automatic pulse_fs();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(3'd0, 32'h0, "R1 ctrl");
    rd_chk(3'd1, 32'h0, "R1 mask");
    rd_chk(3'd2, 32'h0, "R1 status");
    check({line_irq, gfx_filt_act, alpha_filt_act, interlace_mode, alpha_nearest},
          5'b00001, "R1 outputs");

    // R9 reserved bits via vector table
    for (int i = 0; i < 7; i++) begin
      wr(VECS[i][66:64], VECS[i][63:32]);
      rd_chk(VECS[i][66:64], VECS[i][31:0], "R9 table");
    end

    // R4 staging
    wr(3'd0, 32'h0000_5000);
    rd_chk(3'd0, 32'h0000_5000, "R4 staged readback");
    check({gfx_filt_act, alpha_filt_act}, 2'b00, "R4 not yet active");
    pulse_fs();
    check({gfx_filt_act, alpha_filt_act}, 2'b11, "R4 active after frame");
    rd_chk(3'd2, 32'h6, "R4 status");
    check(alpha_nearest, 1'b0, "R6 both on");

    // R6 gfx off alpha on
    wr(3'd0, 32'h0000_4000);
    pulse_fs();
    check({gfx_filt_act, alpha_filt_act, alpha_nearest}, 3'b011, "R6 gfx off");

    // R5 write coincident with frame start
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_1000; frame_start = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; frame_start = 1'b0;
    check({gfx_filt_act, alpha_filt_act}, 2'b01, "R5 old staged loaded");
    pulse_fs();
    check({gfx_filt_act, alpha_filt_act, alpha_nearest}, 3'b101, "R5 new at next frame");

    // R11 interlace
    wr(3'd0, 32'h1000_0000);
    check(interlace_mode, 1'b1, "R11 on");
    wr(3'd0, 32'h0064_0000);
    check(interlace_mode, 1'b0, "R11 off");

    // R2/R3 line interrupt at line 100
    check(line_irq, 1'b0, "R2 before match");
    @(negedge clk); scan_line = 11'd100;
    @(negedge clk); scan_line = 11'd101;
    check(line_irq, 1'b1, "R2 set on match");
    @(negedge clk);
    reg_addr = 3'd2; #1;
    check(reg_rdata & 32'h1, 32'h1, "R2 sticky");
    wr(3'd1, 32'h1);
    check(line_irq, 1'b0, "R3 masked");
    wr(3'd1, 32'h0);
    check(line_irq, 1'b1, "R3 unmasked");

    // R10 clear, and match wins over clear
    wr(3'd2, 32'h1);
    check(line_irq, 1'b0, "R10 cleared");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1; scan_line = 11'd100;
    @(negedge clk);
    reg_wr = 1'b0; scan_line = 11'd2000;
    check(line_irq, 1'b1, "R10 match beats clear");
    wr(3'd2, 32'h1);
    check(line_irq, 1'b0, "R10 cleared again");

    // R7 window
    wr(3'd0, 32'h2000_0205);
    wr(3'd4, 32'h0000_ABCD);
    wr(3'd3, 32'h0000_1234);
    rd_chk(3'd3, 32'h1234, "R7 lb1 low");
    rd_chk(3'd4, 32'hABCD, "R7 lb1 high");
    wr(3'd0, 32'h4000_0205);
    wr(3'd4, 32'h0000_1111);
    wr(3'd3, 32'h0000_2222);
    rd_chk(3'd3, 32'h2222, "R7 lb2 low");
    wr(3'd0, 32'h2000_0607);
    wr(3'd4, 32'h0000_5555);
    wr(3'd3, 32'h0000_6666);
    rd_chk(3'd4, 32'h5555, "R7 ff1 high");
    wr(3'd0, 32'h2000_0205);
    rd_chk(3'd3, 32'h1234, "R7 lb1 separate");

    // R8 disabled and invalid targets
    wr(3'd0, 32'h2000_0005);
    rd_chk(3'd3, 32'h0, "R8 disabled read");
    wr(3'd4, 32'h0000_8888);
    wr(3'd3, 32'h0000_9999);
    wr(3'd0, 32'h6000_0205);
    rd_chk(3'd3, 32'h0, "R8 lb code 3 read");
    wr(3'd3, 32'h0000_7777);
    wr(3'd0, 32'h4000_0605);
    rd_chk(3'd3, 32'h0, "R8 ff code 2 read");
    wr(3'd3, 32'h0000_7777);
    wr(3'd0, 32'h2000_0205);
    rd_chk(3'd3, 32'h1234, "R8 lb1 low untouched");
    rd_chk(3'd4, 32'hABCD, "R8 lb1 high untouched");
    wr(3'd0, 32'h4000_0205);
    rd_chk(3'd3, 32'h2222, "R8 lb2 untouched");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule